// File: doc/BRIEF.md
# DMA descriptor chaining controller

This block runs one DMA channel through a linked list of four-word transfer control blocks stored in internal memory. A host starts it by writing a chain pointer. The low 19 bits of the pointer give the offset of a descriptor, and the top bit is an interrupt-mode flag. The controller adds the fixed internal-memory origin to the offset. It then reads the descriptor over a simple read port with a ready handshake, loads its address generator, and issues one transfer address per accepted word.

When a block's count runs out, the controller decides whether to raise its interrupt and then follows the descriptor's link word. A link whose address field is zero ends the chain and returns the channel to idle. If the host writes a new pointer while a descriptor is being fetched or transferred, the new pointer is held and replaces the link at the next descriptor boundary. The interrupt is a one-cycle pulse that also sets a sticky status bit. The host clears that bit with a write-one-to-clear strobe.

Top module: `dma_chain_ctrl`

## Requirements
- R1: A pointer word has the interrupt flag in bit 19 and the descriptor offset in bits 18:0. A write while idle with a nonzero offset starts a fetch at the next cycle. A write with a zero offset leaves the channel idle, with no read and no interrupt.
- R2: A descriptor is read as four words at origin+offset+0, +1, +2 and +3. Word 0 is the link (pointer format, bits 19:0), word 1 is the count (bits 15:0), word 2 is the modifier (bits 18:0, two's complement) and word 3 is the start index (bits 18:0). One word is taken per cycle in which request and ready are both high.
- R3: Every fetch and transfer address equals the origin 0x80000 plus a 19-bit offset.
- R4: No transfer is issued until all four descriptor words are read. Exactly count transfers follow, each accepted when valid and ready are both high. Transfer k uses index + k*modifier, taken modulo 2^19.
- R5: A descriptor with a zero count issues no transfer. It still follows its link and obeys its interrupt flag.
- R6: The flag that governs a descriptor is bit 19 of the pointer that selected it. When that flag is set, one interrupt follows the block. When it is clear, an interrupt follows only if the block ends the chain.
- R7: A link with a zero offset ends the chain. The channel then goes idle, busy_o falls and one interrupt is raised.
- R8: A pointer write while a descriptor is being fetched or transferred is held. At the end of that block it replaces the link, and its bit 19 becomes the next descriptor's flag.
- R9: irq_pulse_o is high for one cycle and sets irq_status_o in the same cycle. irq_status_o stays set until irq_clr_i is asserted, and a new pulse wins over a clear.
- R10: After reset the channel is idle, with no request, no transfer and the status bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_wr_i | input | 1 | Chain pointer write strobe |
| cp_wdata_i | input | 20 | Chain pointer value: flag in bit 19, offset in bits 18:0 |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 20 | Descriptor word address |
| mem_ready_i | input | 1 | Read data valid; the word is accepted |
| mem_rdata_i | input | 32 | Descriptor word |
| xfer_valid_o | output | 1 | Transfer address valid |
| xfer_addr_o | output | 20 | Transfer word address |
| xfer_ready_i | input | 1 | Transfer word accepted |
| busy_o | output | 1 | Channel is not idle |
| irq_pulse_o | output | 1 | One-cycle channel interrupt |
| irq_status_o | output | 1 | Sticky interrupt status |

## Verification
A wrong fetch-word select shows at the read port within one accepted read: a word address goes out of sequence, or the transfer stream starts from the wrong index. A wrong count or modifier shows in the first transfer address or in the number of transfers before busy_o falls. A wrong flag or a lost held pointer shows at the end of the block concerned: the interrupt count is off, or the chain takes the wrong next descriptor. The bench checks transfer and fetch address logs, interrupt counts, the status bit and the idle state after every chain.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_DONE  = 2'd3
  } chain_state_e;

  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
  parameter int PTR_W  = 20,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PTR_W-1:0]   start_addr_i,
  output logic               mem_req_o,
  output logic [PTR_W-1:0]   mem_addr_o,
  input  logic               mem_ready_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               done_o,
  output logic               last_word_o,
  output logic [PTR_W-1:0]   link_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [PTR_W-2:0]   mod_o,
  output logic [PTR_W-2:0]   idx_o
);
  import dma_chain_pkg::*;
  localparam int OFS_W = PTR_W - 1;
  localparam int SEL_W = $clog2(DESC_WORDS);
  localparam int HELD  = DESC_WORDS - 1;

  logic              fetching_q;
  logic [SEL_W-1:0]  sel_q;
  logic [PTR_W-1:0]  base_q;
  logic [WORD_W-1:0] word_q [HELD];
  logic              unused_hi;

  assign mem_req_o   = fetching_q;
  assign mem_addr_o  = base_q + PTR_W'(sel_q);
  assign last_word_o = fetching_q && (sel_q == SEL_W'(HELD));
  assign done_o      = last_word_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetching_q <= 1'b0;
      sel_q      <= '0;
      base_q     <= '0;
    end else if (start_i) begin
      fetching_q <= 1'b1;
      sel_q      <= '0;
      base_q     <= start_addr_i;
    end else if (fetching_q && mem_ready_i) begin
      sel_q <= sel_q + 1'b1;
      if (last_word_o) fetching_q <= 1'b0;
    end
  end

  // words 0..2 are held; word 3 (index) is consumed straight from the bus
  for (genvar w = 0; w < HELD; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              word_q[w] <= '0;
      else if (fetching_q && mem_ready_i && sel_q == SEL_W'(w)) word_q[w] <= mem_rdata_i;
    end
  end

  assign link_o = word_q[0][PTR_W-1:0];
  assign cnt_o  = word_q[1][CNT_W-1:0];
  assign mod_o  = word_q[2][OFS_W-1:0];
  assign idx_o  = mem_rdata_i[OFS_W-1:0];

  assign unused_hi = ^{word_q[0][WORD_W-1:PTR_W], word_q[1][WORD_W-1:CNT_W],
                       word_q[2][WORD_W-1:OFS_W], mem_rdata_i[WORD_W-1:OFS_W]};
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int               PTR_W    = 20,
  parameter int               CNT_W    = 16,
  parameter logic [PTR_W-1:0] MEM_BASE = 20'h80000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PTR_W-2:0] mod_i,
  input  logic [PTR_W-2:0] idx_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] addr_o,
  output logic             last_o,
  output logic [PTR_W-2:0] mod_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-2:0] idx_q, mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      mod_q <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_i;
      idx_q <= idx_i;
      mod_q <= mod_i;
    end else if (step_i) begin
      cnt_q <= cnt_q - 1'b1;
      idx_q <= idx_q + mod_q;  // 19-bit wrap gives signed add
    end
  end

  assign addr_o = MEM_BASE + PTR_W'(idx_q);
  assign last_o = (cnt_q == CNT_W'(1));
  assign mod_o  = mod_q;
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic status_o
);
  logic pulse_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      pulse_q <= fire_i;
      if (fire_i)     status_q <= 1'b1;
      else if (clr_i) status_q <= 1'b0;
    end
  end

  assign pulse_o  = pulse_q;
  assign status_o = status_q;
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int               PTR_W    = 20,
  parameter int               WORD_W   = 32,
  parameter int               CNT_W    = 16,
  parameter logic [PTR_W-1:0] MEM_BASE = 20'h80000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cp_wr_i,
  input  logic [PTR_W-1:0]  cp_wdata_i,
  input  logic              irq_clr_i,
  output logic              mem_req_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              xfer_valid_o,
  output logic [PTR_W-1:0]  xfer_addr_o,
  input  logic              xfer_ready_i,
  output logic              busy_o,
  output logic              irq_pulse_o,
  output logic              irq_status_o
);
  import dma_chain_pkg::*;
  localparam int OFS_W = PTR_W - 1;

  chain_state_e     state_q, state_d;
  logic             pci_q, pend_v_q;
  logic [PTR_W-1:0] pend_q;

  logic             fetch_start, fetch_done, fetch_last;
  logic [PTR_W-1:0] link, start_word, start_addr, next_word;
  logic [CNT_W-1:0] desc_cnt;
  logic [OFS_W-1:0] desc_mod, desc_idx, cur_mod;
  logic             xfer_last, cp_nz, next_nz, fire;

  assign cp_nz      = |cp_wdata_i[OFS_W-1:0];
  assign next_word  = cp_wr_i ? cp_wdata_i : (pend_v_q ? pend_q : link);
  assign next_nz    = |next_word[OFS_W-1:0];
  assign start_word = (state_q == ST_IDLE) ? cp_wdata_i : next_word;
  assign start_addr = MEM_BASE + PTR_W'(start_word[OFS_W-1:0]);
  assign fetch_start = ((state_q == ST_IDLE) && cp_wr_i && cp_nz) ||
                       ((state_q == ST_DONE) && next_nz);
  assign fire = (state_q == ST_DONE) && (pci_q || !next_nz);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cp_wr_i && cp_nz) state_d = ST_FETCH;
      ST_FETCH: if (fetch_done) state_d = (desc_cnt == '0) ? ST_DONE : ST_XFER;
      ST_XFER:  if (xfer_ready_i && xfer_last) state_d = ST_DONE;
      ST_DONE:  state_d = next_nz ? ST_FETCH : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pci_q    <= 1'b0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fetch_start) pci_q <= start_word[PTR_W-1];
      if (state_q == ST_DONE) begin
        pend_v_q <= 1'b0;
      end else if (cp_wr_i && (state_q == ST_FETCH || state_q == ST_XFER)) begin
        pend_v_q <= 1'b1;
        pend_q   <= cp_wdata_i;
      end
    end
  end

  dma_desc_fetch #(.PTR_W(PTR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_fetch (
    .clk_i, .rst_ni,
    .start_i      (fetch_start),
    .start_addr_i (start_addr),
    .mem_req_o, .mem_addr_o, .mem_ready_i, .mem_rdata_i,
    .done_o       (fetch_done),
    .last_word_o  (fetch_last),
    .link_o       (link),
    .cnt_o        (desc_cnt),
    .mod_o        (desc_mod),
    .idx_o        (desc_idx)
  );

  dma_addr_gen #(.PTR_W(PTR_W), .CNT_W(CNT_W), .MEM_BASE(MEM_BASE)) u_agen (
    .clk_i, .rst_ni,
    .load_i (fetch_done),
    .cnt_i  (desc_cnt),
    .mod_i  (desc_mod),
    .idx_i  (desc_idx),
    .step_i (xfer_valid_o && xfer_ready_i),
    .addr_o (xfer_addr_o),
    .last_o (xfer_last),
    .mod_o  (cur_mod)
  );

  dma_irq_unit u_irq (
    .clk_i, .rst_ni,
    .fire_i   (fire),
    .clr_i    (irq_clr_i),
    .pulse_o  (irq_pulse_o),
    .status_o (irq_status_o)
  );

  assign xfer_valid_o = (state_q == ST_XFER);
  assign busy_o       = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_chain_ctrl_chk.sv
module dma_chain_ctrl_chk #(
  parameter int               PTR_W    = 20,
  parameter logic [PTR_W-1:0] MEM_BASE = 20'h80000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cp_wr_i,
  input logic [PTR_W-1:0] cp_wdata_i,
  input logic             irq_clr_i,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic [PTR_W-1:0] mem_addr_o,
  input logic             mem_ready_i,
  input logic             fetch_last,
  input logic             xfer_valid_o,
  input logic             xfer_ready_i,
  input logic [PTR_W-1:0] xfer_addr_o,
  input logic             xfer_last,
  input logic [PTR_W-2:0] cur_mod,
  input logic             irq_pulse_o,
  input logic             irq_status_o
);
  localparam int OFS_W = PTR_W - 1;
  logic [OFS_W-1:0] idx_now;
  assign idx_now = OFS_W'(xfer_addr_o - MEM_BASE);

  a_r1_start_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cp_wr_i && (|cp_wdata_i[OFS_W-1:0])) |=>
      (mem_req_o && mem_addr_o == MEM_BASE + PTR_W'($past(cp_wdata_i[OFS_W-1:0]))));

  a_r1_zero_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cp_wr_i && !(|cp_wdata_i[OFS_W-1:0])) |=> !busy_o);

  a_r2_word_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !fetch_last) |=>
      (mem_req_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xfer_valid_o));

  a_r4_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_ready_i && !xfer_last) |=>
      (xfer_valid_o && idx_now == $past(idx_now) + $past(cur_mod)));

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !xfer_valid_o));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |=> !irq_pulse_o);

  a_r9_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> irq_status_o);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !busy_o) |=> !irq_status_o);
endmodule

bind dma_chain_ctrl dma_chain_ctrl_chk #(.PTR_W(PTR_W), .MEM_BASE(MEM_BASE)) u_chk (
  .clk_i, .rst_ni, .cp_wr_i, .cp_wdata_i, .irq_clr_i, .busy_o,
  .mem_req_o, .mem_addr_o, .mem_ready_i, .fetch_last,
  .xfer_valid_o, .xfer_ready_i, .xfer_addr_o, .xfer_last, .cur_mod,
  .irq_pulse_o, .irq_status_o
);

// File: tb/dma_chain_ctrl_test.sv
`timescale 1ns/1ps
module dma_chain_ctrl_test;
  localparam logic [19:0] BASE = 20'h80000;
  localparam int NV = 7;
  localparam int V_CNT [NV] = '{1, 4, 5, 3, 4, 0, 6};
  localparam int V_MOD [NV] = '{1, 2, -3, 0, 1, 5, -1};
  localparam int V_IDX [NV] = '{'h100, 'h200, 'h300, 'h400, 'h7FFFE, 'h500, 3};
  localparam int V_PCI [NV] = '{0, 1, 0, 1, 0, 1, 0};

  logic clk = 0, rst_ni = 0;
  logic cp_wr = 0, irq_clr = 0, mem_ready = 0, xfer_ready = 0;
  logic [19:0] cp_wdata = '0;
  logic mem_req, xfer_valid, busy, irq_pulse, irq_status;
  logic [19:0] mem_addr, xfer_addr;
  logic [31:0] mem_rdata;
  logic [31:0] mem [256];

  int checks = 0, errors = 0, cyc = 0;
  int xfer_n, fetch_n, irq_n, first_fetch;
  logic [19:0] xlog [64];
  logic [19:0] flog [64];
  bit pulse_run_err = 0, prev_pulse = 0, finished = 0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  dma_chain_ctrl uut (
    .clk_i(clk), .rst_ni, .cp_wr_i(cp_wr), .cp_wdata_i(cp_wdata), .irq_clr_i(irq_clr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .xfer_valid_o(xfer_valid), .xfer_addr_o(xfer_addr), .xfer_ready_i(xfer_ready),
    .busy_o(busy), .irq_pulse_o(irq_pulse), .irq_status_o(irq_status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(int idx, int md, int k);
    return BASE + 20'((idx + k * md) & 'h7FFFF);
  endfunction

  task automatic put_desc(int ptr, logic [19:0] link, int cnt, int md, int idx);
    mem[ptr]   = {12'h0, link};
    mem[ptr+1] = 32'(cnt & 'hFFFF);
    mem[ptr+2] = 32'(md & 'h7FFFF);
    mem[ptr+3] = 32'(idx & 'h7FFFF);
  endtask

  task automatic clear_logs();
    xfer_n = 0; fetch_n = 0; irq_n = 0; first_fetch = -1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_chain(input logic [19:0] cp);
    clear_logs();
    @(negedge clk); cp_wr = 1; cp_wdata = cp;
    @(negedge clk); cp_wr = 0;
    wait_idle();
  endtask

  task automatic clear_status();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  // stall patterns on both handshakes, monitor sampled after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready  = (cyc % 3) != 2;
      xfer_ready = (cyc % 4) != 1;
      #1;
      if (mem_req && mem_ready) begin
        if (fetch_n < 64) flog[fetch_n] = mem_addr;
        fetch_n++;
      end
      if (xfer_valid && xfer_ready) begin
        if (xfer_n == 0) first_fetch = fetch_n;
        if (xfer_n < 64) xlog[xfer_n] = xfer_addr;
        xfer_n++;
      end
      if (irq_pulse) irq_n++;
      if (irq_pulse && prev_pulse) pulse_run_err = 1;
      prev_pulse = irq_pulse;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !mem_req && !xfer_valid && !irq_status && !irq_pulse, "R10 reset",
        {busy, mem_req, xfer_valid, irq_status}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // table of single-descriptor chains
    for (int v = 0; v < NV; v++) begin
      put_desc('h10, 20'h0, V_CNT[v], V_MOD[v], V_IDX[v]);
      run_chain({V_PCI[v][0], 19'h10});
      chk(xfer_n == V_CNT[v], $sformatf("R4 count v%0d", v), xfer_n, V_CNT[v]);
      ok = 1;
      for (int k = 0; k < V_CNT[v]; k++)
        if (xlog[k] !== exp_addr(V_IDX[v], V_MOD[v], k)) ok = 0;
      chk(ok, $sformatf("R3 addresses v%0d", v), xlog[0], exp_addr(V_IDX[v], V_MOD[v], 0));
      chk(fetch_n == 4, $sformatf("R2 fetch count v%0d", v), fetch_n, 4);
      chk(irq_n == 1 && !busy, $sformatf("R7 end irq v%0d", v), irq_n, 1);
      clear_status();
    end
    // R5 zero count (table entry 5) produced no transfer, R3 wrap covered by entries 4 and 6

    // R2/R4: three-block chain, flags clear: one interrupt at the end
    put_desc('h10, 20'h00020, 2, 1, 'h10);
    put_desc('h20, 20'h00030, 3, 4, 'h40);
    put_desc('h30, 20'h00000, 1, 1, 'h80);
    run_chain(20'h00010);
    chk(xfer_n == 6, "R4 chain transfers", xfer_n, 6);
    chk(xlog[2] == BASE + 20'h40 && xlog[4] == BASE + 20'h48 && xlog[5] == BASE + 20'h80,
        "R4 chain addresses", xlog[4], BASE + 20'h48);
    ok = (fetch_n == 12);
    for (int k = 0; k < 12 && ok; k++)
      if (flog[k] !== BASE + 20'((k / 4 + 1) * 'h10 + k % 4)) ok = 0;
    chk(ok, "R2 fetch order", flog[4], BASE + 20'h20);
    chk(first_fetch == 4, "R4 no transfer before load", first_fetch, 4);
    chk(irq_n == 1, "R6 flag clear single irq", irq_n, 1);
    chk(irq_status, "R9 status sticky", irq_status, 1);
    clear_status();
    chk(!irq_status, "R9 write-one-to-clear", irq_status, 0);

    // R6: flags set on every link
    put_desc('h10, 20'h80020, 2, 1, 'h10);
    put_desc('h20, 20'h80030, 3, 4, 'h40);
    put_desc('h30, 20'h00000, 1, 1, 'h80);
    run_chain(20'h80010);
    chk(irq_n == 3, "R6 flag set per block", irq_n, 3);
    chk(!pulse_run_err, "R9 one-cycle pulse", pulse_run_err, 0);
    clear_status();

    // R6 mixed: first block flagged, second not and last
    put_desc('h10, 20'h00020, 2, 1, 'h10);
    put_desc('h20, 20'h00000, 1, 1, 'h40);
    run_chain(20'h80010);
    chk(irq_n == 2, "R6 mixed flags", irq_n, 2);
    clear_status();

    // R5 zero-count block in the middle still links and interrupts
    put_desc('h10, 20'h80040, 2, 1, 'h10);
    put_desc('h40, 20'h00020, 0, 7, 'h99);
    put_desc('h20, 20'h00000, 3, 2, 'h60);
    run_chain(20'h00010);
    chk(xfer_n == 5 && xlog[2] == BASE + 20'h60, "R5 zero count skipped", xfer_n, 5);
    chk(irq_n == 2, "R5 zero count obeys flag", irq_n, 2);
    clear_status();

    // R1 zero offset write while idle
    run_chain(20'h80000);
    chk(!busy && fetch_n == 0 && irq_n == 0 && !irq_status, "R1 zero write idle",
        fetch_n + irq_n, 0);

    // R8 pointer write during a block takes effect at the boundary
    put_desc('h50, 20'h00000, 10, 1, 'h200);
    put_desc('h20, 20'h00000, 3, 1, 'h300);
    clear_logs();
    @(negedge clk); cp_wr = 1; cp_wdata = 20'h00050;
    @(negedge clk); cp_wr = 0;
    repeat (12) @(negedge clk);
    cp_wr = 1; cp_wdata = 20'h00020;
    @(negedge clk); cp_wr = 0;
    chk(busy && xfer_n < 10, "R8 write while active", xfer_n, 10);
    wait_idle();
    chk(xfer_n == 13 && xlog[9] == BASE + 20'h209 && xlog[10] == BASE + 20'h300,
        "R8 held pointer replaces link", xlog[10], BASE + 20'h300);
    chk(irq_n == 1, "R8 irq after redirected chain", irq_n, 1);
    clear_status();

    // R9 pulse wins over simultaneous clear: hold clear through a chain end
    put_desc('h10, 20'h00000, 1, 1, 'h10);
    clear_logs();
    @(negedge clk); cp_wr = 1; cp_wdata = 20'h00010; irq_clr = 1;
    @(negedge clk); cp_wr = 0;
    for (int i = 0; i < 200 && !irq_pulse; i++) @(negedge clk);
    chk(irq_pulse && irq_status, "R9 set wins over clear", irq_status, 1);
    @(negedge clk);
    chk(!irq_status, "R9 clear after pulse", irq_status, 0);
    irq_clr = 0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule